// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and calendar date in packed BCD. It is advanced by a one-cycle tick that arrives once per second from a prescaler outside the block. The counter covers seconds, minutes, hours, day of week, day of month, month and a two-digit year (2000 to 2099). Every field can be read or loaded as a 4-bit nibble through a small address space, so a serial or parallel host interface can sit in front of it without knowing the carry rules.

The hour counter runs in either 24-hour or 12-hour form, chosen by a control bit. In 12-hour form a PM bit is kept beside the hour digits. An adjust command rounds the seconds to the nearest minute. A sticky halt flag is raised at reset, and again whenever the tick stops for longer than a set window. The host uses it to decide whether the stored time can be trusted.

Top module: `rtc_bcd_core`

## Requirements
- R1: Seconds and minutes count in BCD from 00 to 59. Each tick adds one second. 59 seconds wraps to 00 and adds one minute, and 59 minutes wraps to 00 and advances the hour.
- R2: With control bit 0 set (24-hour form), hours run 00 to 23. Leaving 23 gives 00 and advances the day.
- R3: With control bit 0 clear (12-hour form), hours run 12, 01, ..., 11. Going from 11 to 12 toggles the PM bit, which is bit 2 of the hour-tens nibble. The day advances only on the step from 11 PM to 12 AM.
- R4: Months 04, 06, 09 and 11 end after day 30. Months 01, 03, 05, 07, 08, 10 and 12 end after day 31. After the last day comes day 01 of the next month, month 12 is followed by 01, and each month 12 wrap adds one year. Year 99 wraps to 00.
- R5: When the year value (two BCD digits) is divisible by 4, February ends after day 29. In every other year it ends after day 28.
- R6: Day of week counts 0 to 6 and wraps to 0. It advances on exactly the ticks that advance the day of month.
- R7: An adjust pulse clears the seconds to 00. If the seconds were 30 or more, it also adds one minute, with the full carry chain. An adjust pulse overrides a tick in the same cycle.
- R8: A write loads the addressed nibble directly. If a write, a tick or an adjust fall in the same cycle, the write wins: the tick and the adjust are discarded and no other field changes.
- R9: The halt flag (control bit 1) is set at reset, and after TIMEOUT_CYC consecutive cycles without a tick. It stays set until a write to the control address with bit 1 clear. A control write with bit 1 set leaves the flag unchanged.
- R10: Nibble addresses are as follows. Addresses 0 and 1 hold the seconds ones and tens digits, 2 and 3 the minutes, 4 and 5 the day of month, 6 and 7 the month, 8 and 9 the year, and 10 and 11 the hour. Address 12 holds the day of week. Address 15 is control: bit 0 selects 24-hour form and bit 1 is the halt flag. Other addresses read 0. Reset state: 2000-01-01 00:00:00, day of week 0, 24-hour form, PM clear, halt set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| adj_i | input | 1 | One-cycle adjust pulse (round to nearest minute) |
| wr_en_i | input | 1 | Nibble write strobe |
| wr_addr_i | input | 4 | Write nibble address |
| wr_data_i | input | 4 | Write nibble data |
| rd_addr_i | input | 4 | Read nibble address |
| rd_data_o | output | 4 | Read nibble data, combinational from state |
| halt_o | output | 1 | Sticky halt flag |

## Verification
A wrong carry decision shows up on the read port in the cycle right after the tick that crosses the boundary: the seconds/minutes wrap, the hour wrap, a month end, a February end or the year wrap. Day of week and PM are checked on that same tick, so a miscounted carry shows one cycle later. A fault in the halt window shows on halt_o only after TIMEOUT_CYC idle cycles, so the bench checks the flag just before and just after that window. Adjust and write-priority errors corrupt the seconds or minutes one cycle after the pulse, and every test then reads both fields back.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned NFLD   = 5;

  // two-digit fields, addresses 2*i (ones) and 2*i+1 (tens)
  localparam int unsigned F_SEC = 0;
  localparam int unsigned F_MIN = 1;
  localparam int unsigned F_DAY = 2;
  localparam int unsigned F_MON = 3;
  localparam int unsigned F_YR  = 4;

  localparam logic [ADDR_W-1:0] A_HR_O = 4'd10;
  localparam logic [ADDR_W-1:0] A_HR_T = 4'd11;
  localparam logic [ADDR_W-1:0] A_WDAY = 4'd12;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd15;

  function automatic logic [7:0] fld_first(int unsigned i);
    return (i == F_DAY || i == F_MON) ? 8'h01 : 8'h00;
  endfunction
endpackage

// File: rtl/rtc_bcd_step.sv
module rtc_bcd_step #(
  parameter logic [7:0] FIRST = 8'h00
) (
  input  logic [7:0] val_i,
  input  logic [7:0] last_i,
  input  logic       inc_i,
  output logic [7:0] nxt_o,
  output logic       at_last_o
);
  assign at_last_o = (val_i == last_i);

  always_comb begin
    nxt_o = val_i;
    if (inc_i) begin
      if (at_last_o)              nxt_o = FIRST;
      else if (val_i[3:0] == 4'h9) nxt_o = {val_i[7:4] + 4'h1, 4'h0};
      else                        nxt_o = val_i + 8'h01;
    end
  end
endmodule

// File: rtl/rtc_hour_step.sv
module rtc_hour_step (
  input  logic [7:0] hr_i,
  input  logic       pm_i,
  input  logic       mode24_i,
  input  logic       inc_i,
  output logic [7:0] hr_o,
  output logic       pm_o,
  output logic       day_o
);
  always_comb begin
    hr_o  = hr_i;
    pm_o  = pm_i;
    day_o = 1'b0;
    if (inc_i) begin
      if (mode24_i && hr_i == 8'h23) begin
        hr_o  = 8'h00;
        day_o = 1'b1;
      end else if (!mode24_i && hr_i == 8'h11) begin
        hr_o  = 8'h12;
        pm_o  = ~pm_i;
        day_o = pm_i;
      end else if (!mode24_i && hr_i == 8'h12) begin
        hr_o  = 8'h01;
      end else if (hr_i[3:0] == 4'h9) begin
        hr_o  = {hr_i[7:4] + 4'h1, 4'h0};
      end else begin
        hr_o  = hr_i + 8'h01;
      end
    end
  end
endmodule

// File: rtl/rtc_month_len.sv
module rtc_month_len (
  input  logic [7:0] mon_i,
  input  logic [7:0] yr_i,
  output logic [7:0] last_day_o
);
  logic leap;

  // 10t+o divisible by 4 <=> 2t+o divisible by 4
  always_comb begin
    if (yr_i[4]) leap = (yr_i[3:0] == 4'h2) || (yr_i[3:0] == 4'h6);
    else         leap = (yr_i[3:0] == 4'h0) || (yr_i[3:0] == 4'h4) || (yr_i[3:0] == 4'h8);
  end

  always_comb begin
    case (mon_i)
      8'h02:                      last_day_o = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: last_day_o = 8'h30;
      default:                    last_day_o = 8'h31;
    endcase
  end
endmodule

// File: rtl/rtc_halt_mon.sv
module rtc_halt_mon #(
  parameter int unsigned TIMEOUT_CYC = 200_000_000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic clr_i,
  output logic halt_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);
  localparam logic [CW-1:0] LIM = CW'(TIMEOUT_CYC - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      halt_o <= 1'b1;
    end else begin
      if (tick_i || clr_i)  cnt_q <= '0;
      else if (cnt_q != LIM) cnt_q <= cnt_q + 1'b1;
      if (clr_i)                         halt_o <= 1'b0;
      else if (!tick_i && cnt_q == LIM)  halt_o <= 1'b1;
    end
  end
endmodule

// File: rtl/rtc_bcd_core.sv
module rtc_bcd_core
  import rtc_pkg::*;
#(
  parameter int unsigned TIMEOUT_CYC = 200_000_000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              adj_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [NIB_W-1:0]  wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [NIB_W-1:0]  rd_data_o,
  output logic              halt_o
);
  logic [7:0]      fld_q   [NFLD];
  logic [7:0]      fld_nxt [NFLD];
  logic [7:0]      last_v  [NFLD];
  logic [NFLD-1:0] at_last;
  logic [NFLD-1:0] inc_v;
  logic [7:0]      hr_q, hr_nxt, mlen;
  logic            pm_q, pm_nxt, day_carry, mode24_q;
  logic [2:0]      wday_q;
  logic            adv, adj_go, adj_carry, halt_clr;
  logic            unused_yr_wrap;

  assign adv       = tick_i & ~adj_i & ~wr_en_i;
  assign adj_go    = adj_i & ~wr_en_i;
  assign adj_carry = adj_go & (fld_q[F_SEC] >= 8'h30);
  assign halt_clr  = wr_en_i && wr_addr_i == A_CTRL && !wr_data_i[1];
  assign unused_yr_wrap = at_last[F_YR];

  assign last_v[F_SEC] = 8'h59;
  assign last_v[F_MIN] = 8'h59;
  assign last_v[F_DAY] = mlen;
  assign last_v[F_MON] = 8'h12;
  assign last_v[F_YR]  = 8'h99;

  assign inc_v[F_SEC] = adv;
  assign inc_v[F_MIN] = (adv & at_last[F_SEC]) | adj_carry;
  assign inc_v[F_DAY] = day_carry;
  assign inc_v[F_MON] = day_carry & at_last[F_DAY];
  assign inc_v[F_YR]  = day_carry & at_last[F_DAY] & at_last[F_MON];

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    rtc_bcd_step #(.FIRST(fld_first(i))) i_step (
      .val_i    (fld_q[i]),
      .last_i   (last_v[i]),
      .inc_i    (inc_v[i]),
      .nxt_o    (fld_nxt[i]),
      .at_last_o(at_last[i])
    );
  end

  rtc_hour_step i_hour (
    .hr_i    (hr_q),
    .pm_i    (pm_q),
    .mode24_i(mode24_q),
    .inc_i   (inc_v[F_MIN] & at_last[F_MIN]),
    .hr_o    (hr_nxt),
    .pm_o    (pm_nxt),
    .day_o   (day_carry)
  );

  rtc_month_len i_mlen (
    .mon_i     (fld_q[F_MON]),
    .yr_i      (fld_q[F_YR]),
    .last_day_o(mlen)
  );

  rtc_halt_mon #(.TIMEOUT_CYC(TIMEOUT_CYC)) i_halt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick_i),
    .clr_i (halt_clr),
    .halt_o(halt_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NFLD; i++) fld_q[i] <= fld_first(i);
      hr_q     <= 8'h00;
      pm_q     <= 1'b0;
      wday_q   <= 3'd0;
      mode24_q <= 1'b1;
    end else begin
      for (int i = 0; i < NFLD; i++) fld_q[i] <= fld_nxt[i];
      hr_q <= hr_nxt;
      pm_q <= pm_nxt;
      if (day_carry) wday_q <= (wday_q == 3'd6) ? 3'd0 : wday_q + 3'd1;
      if (adj_go) fld_q[F_SEC] <= 8'h00;
      if (wr_en_i) begin
        for (int i = 0; i < NFLD; i++) begin
          if (wr_addr_i == ADDR_W'(2 * i))     fld_q[i][3:0] <= wr_data_i;
          if (wr_addr_i == ADDR_W'(2 * i + 1)) fld_q[i][7:4] <= wr_data_i;
        end
        case (wr_addr_i)
          A_HR_O: hr_q[3:0] <= wr_data_i;
          A_HR_T: begin
            hr_q[7:4] <= {2'b00, wr_data_i[1:0]};
            pm_q      <= wr_data_i[2];
          end
          A_WDAY: wday_q   <= wr_data_i[2:0];
          A_CTRL: mode24_q <= wr_data_i[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NFLD; i++) begin
      if (rd_addr_i == ADDR_W'(2 * i))     rd_data_o = fld_q[i][3:0];
      if (rd_addr_i == ADDR_W'(2 * i + 1)) rd_data_o = fld_q[i][7:4];
    end
    case (rd_addr_i)
      A_HR_O:  rd_data_o = hr_q[3:0];
      A_HR_T:  rd_data_o = {1'b0, pm_q, hr_q[5:4]};
      A_WDAY:  rd_data_o = {1'b0, wday_q};
      A_CTRL:  rd_data_o = {2'b00, halt_o, mode24_q};
      default: ;
    endcase
  end
endmodule

// File: rtl/rtc_bcd_core_chk.sv
module rtc_bcd_core_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tick_i,
  input logic       adj_i,
  input logic       wr_en_i,
  input logic [3:0] wr_addr_i,
  input logic [3:0] wr_data_i,
  input logic       halt_i,
  input logic [7:0] sec_i,
  input logic [7:0] hr_i,
  input logic       mode24_i,
  input logic [2:0] wday_i
);
  p_sec_bcd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sec_i[7:4] <= 4'h5 && sec_i[3:0] <= 4'h9);

  p_hr24_range_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode24_i |-> hr_i <= 8'h23);

  p_wday_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wday_i <= 3'd6);

  p_adj_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adj_i && !wr_en_i |=> sec_i == 8'h00);

  p_wr_over_tick_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && wr_en_i && wr_addr_i[3:1] != 3'd0 |=> $stable(sec_i));

  p_halt_sticky_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !(wr_en_i && wr_addr_i == 4'hF && !wr_data_i[1]) |=> halt_i);

  p_halt_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && wr_addr_i == 4'hF && !wr_data_i[1] |=> !halt_i);
endmodule

bind rtc_bcd_core rtc_bcd_core_chk i_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .adj_i    (adj_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .halt_i   (halt_o),
  .sec_i    (fld_q[0]),
  .hr_i     (hr_q),
  .mode24_i (mode24_q),
  .wday_i   (wday_q)
);

// File: tb/test_rtc_bcd_core.sv
module test_rtc_bcd_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0, adj = 1'b0, wr_en = 1'b0;
  logic [3:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [3:0] rd_data;
  logic       halt;
  int         checks = 0, failures = 0;

  always #5 clk = ~clk;

  rtc_bcd_core #(.TIMEOUT_CYC(50)) i_rtc_bcd_core (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .adj_i(adj),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .halt_o(halt)
  );

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse_tick();
    @(negedge clk); tick = 1'b1;
    @(negedge clk); tick = 1'b0;
  endtask

  task automatic rd8(input logic [3:0] lo, output logic [7:0] v);
    rd_addr = lo;      #1; v[3:0] = rd_data;
    rd_addr = lo + 1;  #1; v[7:4] = rd_data;
  endtask

  task automatic rd4(input logic [3:0] a, output logic [7:0] v);
    rd_addr = a; #1; v = {4'h0, rd_data};
  endtask

  task automatic set_time(input logic [7:0] h, input logic pm, input logic [7:0] m, input logic [7:0] s);
    wr(4'd10, h[3:0]); wr(4'd11, {1'b0, pm, h[5:4]});
    wr(4'd2, m[3:0]);  wr(4'd3, m[7:4]);
    wr(4'd0, s[3:0]);  wr(4'd1, s[7:4]);
  endtask

  task automatic set_date(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d);
    wr(4'd8, y[3:0]);  wr(4'd9, y[7:4]);
    wr(4'd6, mo[3:0]); wr(4'd7, mo[7:4]);
    wr(4'd4, d[3:0]);  wr(4'd5, d[7:4]);
  endtask

  // day rollover from 23:59:59 (24h) and report new month/day
  task automatic roll_day(input logic [7:0] y, input logic [7:0] mo, input logic [7:0] d,
                          input string tag, input logic [7:0] exp_mo, input logic [7:0] exp_d);
    logic [7:0] v;
    set_date(y, mo, d);
    set_time(8'h23, 1'b0, 8'h59, 8'h59);
    pulse_tick();
    rd8(4'd6, v); check({tag, " month"}, v, exp_mo);
    rd8(4'd4, v); check({tag, " day"}, v, exp_d);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    rd8(4'd0, v); check("R10 reset sec", v, 8'h00);
    rd8(4'd10, v); check("R10 reset hour", v, 8'h00);
    rd8(4'd4, v); check("R10 reset day", v, 8'h01);
    rd8(4'd6, v); check("R10 reset month", v, 8'h01);
    rd8(4'd8, v); check("R10 reset year", v, 8'h00);
    rd4(4'd12, v); check("R10 reset wday", v, 8'h00);
    rd4(4'd15, v); check("R9 R10 reset ctrl", v, 8'h03);
    rd4(4'd13, v); check("R10 unused address", v, 8'h00);
  endtask

  task automatic t_carry24();
    logic [7:0] v;
    set_time(8'h09, 1'b0, 8'h00, 8'h58);
    pulse_tick();
    rd8(4'd0, v); check("R1 sec step", v, 8'h59);
    pulse_tick();
    rd8(4'd0, v); check("R1 sec wrap", v, 8'h00);
    rd8(4'd2, v); check("R1 min carry", v, 8'h01);
    set_time(8'h09, 1'b0, 8'h59, 8'h59);
    pulse_tick();
    rd8(4'd10, v); check("R2 hour 09->10", v, 8'h10);
    rd8(4'd2, v); check("R1 min wrap", v, 8'h00);
    set_time(8'h23, 1'b0, 8'h59, 8'h59);
    pulse_tick();
    rd8(4'd10, v); check("R2 hour 23->00", v, 8'h00);
    rd8(4'd4, v); check("R2 day carry", v, 8'h02);
    rd4(4'd12, v); check("R6 wday 0->1", v, 8'h01);
  endtask

  task automatic t_months();
    roll_day(8'h23, 8'h04, 8'h30, "R4 apr end", 8'h05, 8'h01);
    roll_day(8'h23, 8'h01, 8'h30, "R4 jan 30", 8'h01, 8'h31);
    roll_day(8'h23, 8'h01, 8'h31, "R4 jan end", 8'h02, 8'h01);
    roll_day(8'h23, 8'h11, 8'h30, "R4 nov end", 8'h12, 8'h01);
    begin
      logic [7:0] v;
      roll_day(8'h99, 8'h12, 8'h31, "R4 year wrap", 8'h01, 8'h01);
      rd8(4'd8, v); check("R4 year 99->00", v, 8'h00);
      roll_day(8'h19, 8'h12, 8'h31, "R4 year carry", 8'h01, 8'h01);
      rd8(4'd8, v); check("R4 year 19->20", v, 8'h20);
    end
  endtask

  task automatic t_leap();
    roll_day(8'h24, 8'h02, 8'h28, "R5 leap 24", 8'h02, 8'h29);
    roll_day(8'h24, 8'h02, 8'h29, "R5 leap 24 end", 8'h03, 8'h01);
    roll_day(8'h23, 8'h02, 8'h28, "R5 plain 23", 8'h03, 8'h01);
    roll_day(8'h10, 8'h02, 8'h28, "R5 plain 10", 8'h03, 8'h01);
    roll_day(8'h12, 8'h02, 8'h28, "R5 leap 12", 8'h02, 8'h29);
    roll_day(8'h00, 8'h02, 8'h28, "R5 leap 00", 8'h02, 8'h29);
  endtask

  task automatic t_hour12();
    logic [7:0] v;
    wr(4'd15, 4'b0000);
    rd4(4'd15, v); check("R3 12h mode selected", v, 8'h00);
    set_date(8'h23, 8'h03, 8'h10);
    set_time(8'h11, 1'b0, 8'h59, 8'h59);
    pulse_tick();
    rd8(4'd10, v); check("R3 11 AM -> 12 PM", v, 8'h52);
    rd8(4'd4, v); check("R3 no day carry at noon", v, 8'h10);
    set_time(8'h12, 1'b1, 8'h59, 8'h59);
    pulse_tick();
    rd8(4'd10, v); check("R3 12 PM -> 01 PM", v, 8'h41);
    set_time(8'h09, 1'b1, 8'h59, 8'h59);
    pulse_tick();
    rd8(4'd10, v); check("R3 09 PM -> 10 PM", v, 8'h50);
    set_time(8'h11, 1'b1, 8'h59, 8'h59);
    pulse_tick();
    rd8(4'd10, v); check("R3 11 PM -> 12 AM", v, 8'h12);
    rd8(4'd4, v); check("R3 day carry at midnight", v, 8'h11);
    wr(4'd15, 4'b0001);
  endtask

  task automatic t_wday();
    logic [7:0] v;
    set_date(8'h23, 8'h03, 8'h10);
    wr(4'd12, 4'd6);
    set_time(8'h23, 1'b0, 8'h59, 8'h59);
    pulse_tick();
    rd4(4'd12, v); check("R6 wday 6->0", v, 8'h00);
    set_time(8'h22, 1'b0, 8'h59, 8'h59);
    pulse_tick();
    rd4(4'd12, v); check("R6 wday holds without day step", v, 8'h00);
  endtask

  task automatic t_adjust();
    logic [7:0] v;
    set_time(8'h10, 1'b0, 8'h05, 8'h29);
    @(negedge clk); adj = 1'b1; @(negedge clk); adj = 1'b0;
    rd8(4'd0, v); check("R7 adj 29 sec", v, 8'h00);
    rd8(4'd2, v); check("R7 adj 29 min", v, 8'h05);
    set_time(8'h10, 1'b0, 8'h59, 8'h30);
    @(negedge clk); adj = 1'b1; @(negedge clk); adj = 1'b0;
    rd8(4'd0, v); check("R7 adj 30 sec", v, 8'h00);
    rd8(4'd2, v); check("R7 adj 30 min wrap", v, 8'h00);
    rd8(4'd10, v); check("R7 adj hour carry", v, 8'h11);
    set_time(8'h10, 1'b0, 8'h20, 8'h10);
    @(negedge clk); adj = 1'b1; tick = 1'b1; @(negedge clk); adj = 1'b0; tick = 1'b0;
    rd8(4'd0, v); check("R7 adj over tick sec", v, 8'h00);
    rd8(4'd2, v); check("R7 adj over tick min", v, 8'h20);
  endtask

  task automatic t_write_prio();
    logic [7:0] v;
    set_time(8'h10, 1'b0, 8'h20, 8'h10);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd2; wr_data = 4'd7;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    rd8(4'd0, v); check("R8 tick dropped on write", v, 8'h10);
    rd8(4'd2, v); check("R8 write loads min ones", v, 8'h27);
    @(negedge clk); adj = 1'b1; wr_en = 1'b1; wr_addr = 4'd3; wr_data = 4'd4;
    @(negedge clk); adj = 1'b0; wr_en = 1'b0;
    rd8(4'd0, v); check("R8 adjust dropped on write", v, 8'h10);
    rd8(4'd2, v); check("R8 write loads min tens", v, 8'h47);
  endtask

  task automatic t_halt();
    logic [7:0] v;
    pulse_tick();
    wr(4'd15, 4'b0001);
    check("R9 cleared by write", {7'd0, halt}, 8'h00);
    repeat (20) @(negedge clk);
    pulse_tick();
    repeat (40) @(negedge clk);
    check("R9 ticks keep flag clear", {7'd0, halt}, 8'h00);
    repeat (20) @(negedge clk);
    check("R9 set after timeout", {7'd0, halt}, 8'h01);
    wr(4'd15, 4'b0011);
    rd4(4'd15, v); check("R9 write with bit1 set keeps flag", v, 8'h03);
    pulse_tick();
    check("R9 tick does not clear", {7'd0, halt}, 8'h01);
    wr(4'd15, 4'b0001);
    rd4(4'd15, v); check("R9 clear via control", v, 8'h01);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_carry24();
    t_months();
    t_leap();
    t_hour12();
    t_wday();
    t_adjust();
    t_write_prio();
    t_halt();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule